// File: doc/BRIEF.md
# Sequential Unsigned Integer Divider

This block divides one unsigned integer by another over a series of clock cycles and produces one quotient bit per cycle. A single shared datapath holds a sign-extended partial-remainder register, a shift register that starts with the dividend and ends with the quotient, and a register that holds the divisor. For each operation the caller selects one of two iteration schemes. The restoring scheme undoes a failed trial subtraction. The non-restoring scheme carries a negative partial remainder into the next step as an addition and corrects the remainder in one extra cycle at the end.

The caller places the operands and the scheme select on the inputs and raises the start strobe for one clock. The block ignores further strobes until it returns to idle. When the result is ready it raises a one-cycle completion pulse. Quotient and remainder then stay on the outputs until the next operation is accepted. A zero divisor never enters the iteration loop. It finishes on the next cycle and sets a flag.

Top module: `seqdiv_unit`

## Requirements
- R1: With `mode_i` = 0 (restoring), a completed operation with non-zero divisor gives `quotient_o` = floor(dividend / divisor) and `remainder_o` = dividend mod divisor. For example, 21 / 5 gives quotient 4 and remainder 1.
- R2: With `mode_i` = 1 (non-restoring), a completed operation with non-zero divisor gives the same quotient and remainder as R1, with a remainder always in [0, divisor). For example, 21 / 5 gives quotient 4 and remainder 1.
- R3: An operation is accepted on a rising edge where `start_i` = 1 and the block is idle. If that edge is edge k, `done_o` goes high after edge k+W in restoring mode and after edge k+W+1 in non-restoring mode. The extra cycle is the remainder correction.
- R4: `done_o` is high for exactly one clock cycle per completed operation.
- R5: A zero divisor completes after the accepting edge itself, with no iterations. It sets `div_zero_o` = 1, `quotient_o` = all ones and `remainder_o` = the dividend.
- R6: `div_zero_o` is 0 at the completion of any accepted operation whose divisor is non-zero.
- R7: While an operation is running, `start_i`, the operands and `mode_i` are ignored. The result and the completion time are those of the accepted operation.
- R8: After completion, `quotient_o`, `remainder_o` and `div_zero_o` hold their values until the next accepted operation, whatever the operand inputs do.
- R9: While `rst_n` = 0 at a rising edge, the block returns to idle with `done_o` = 0, `div_zero_o` = 0, `quotient_o` = 0 and `remainder_o` = 0. An operation cut off by reset never signals completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| mode_i | input | 1 | Scheme select: 0 restoring, 1 non-restoring |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| quotient_o | output | W | Quotient, valid from the completion pulse |
| remainder_o | output | W | Remainder, valid from the completion pulse |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Set when the accepted divisor was zero |

## Verification
The bound checker records the operands and scheme on every accepted start. On every cycle it enforces that a completion satisfies quotient × divisor + remainder = dividend with the remainder below the divisor, that the completion arrives after exactly W or W+1 cycles, that the pulse lasts one cycle, that a zero divisor completes at once with the flag, and that idle outputs stay still. Only the bench's scenarios can show the exact all-ones quotient of a divide by zero, that operands changed during a run are truly ignored, and that a reset in mid-operation suppresses completion. The vector table also pins both schemes to the same expected answer, including the cases at the operand range limits.

// File: rtl/seqdiv_pkg.sv
// Package: shared types for the sequential divider.
// Assumes: nothing beyond IEEE 1800-2017.
package seqdiv_pkg;

    // Controller phase of an operation
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } seqdiv_state_e;

    // Iteration scheme chosen per operation
    typedef enum logic {
        ALG_RESTORE = 1'b0,
        ALG_NONREST = 1'b1
    } seqdiv_alg_e;

endpackage

// File: rtl/seqdiv_addsub.sv
// Module: seqdiv_addsub
// Two's-complement adder/subtractor of width WD, shared by every step of
// both division schemes. y = a + b when sub_i = 0, y = a - b when sub_i = 1.
// Assumes: the result wraps modulo 2**WD; the caller keeps values in range.
module seqdiv_addsub #(
    parameter int WD = 9
) (
    input  logic [WD-1:0] a_i,
    input  logic [WD-1:0] b_i,
    input  logic          sub_i,
    output logic [WD-1:0] y_o
);

    logic [WD-1:0] b_eff;

    // Invert the right operand for subtraction; the carry-in completes it
    always_comb begin
        b_eff = b_i ^ {WD{sub_i}};
        y_o   = a_i + b_eff + {{(WD-1){1'b0}}, sub_i};
    end

endmodule

// File: rtl/seqdiv_ctrl.sv
// Module: seqdiv_ctrl
// Sequencer for the divider: accepts a start when idle, runs W iteration
// cycles, adds one correction cycle for the non-restoring scheme, and
// produces the completion pulse and the divide-by-zero flag.
// Assumes: divisor_zero_i reflects the divisor presented with start_i.
module seqdiv_ctrl
    import seqdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        mode_i,
    input  logic        divisor_zero_i,
    output logic        load_o,
    output logic        zload_o,
    output logic        step_o,
    output logic        fix_o,
    output seqdiv_alg_e alg_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        div_zero_o
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    seqdiv_state_e state_q;
    logic [CW-1:0] step_cnt_q;
    seqdiv_alg_e   alg_q;
    logic          done_q;
    logic          dz_q;
    logic          accept;

    // Decode the datapath strobes from the current phase
    always_comb begin
        accept  = (state_q == ST_IDLE) && start_i;
        load_o  = accept && !divisor_zero_i;
        zload_o = accept && divisor_zero_i;
        step_o  = (state_q == ST_ITER);
        fix_o   = (state_q == ST_FIX);
        busy_o  = (state_q != ST_IDLE);
    end

    // Phase register, iteration counter and latched scheme
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_cnt_q <= '0;
            alg_q      <= ALG_RESTORE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load_o) begin
                        state_q    <= ST_ITER;
                        step_cnt_q <= '0;
                        alg_q      <= seqdiv_alg_e'(mode_i);
                    end
                end
                ST_ITER: begin
                    step_cnt_q <= step_cnt_q + 1'b1;
                    if (step_cnt_q == LAST_STEP) begin
                        state_q <= (alg_q == ALG_NONREST) ? ST_FIX : ST_IDLE;
                    end
                end
                ST_FIX: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Completion pulse: high for the one cycle after the finishing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= zload_o
                   || (fix_o)
                   || (step_o && (step_cnt_q == LAST_STEP) && (alg_q == ALG_RESTORE));
        end
    end

    // Divide-by-zero flag: set by a zero-divisor start, cleared by any other
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dz_q <= 1'b0;
        end else if (accept) begin
            dz_q <= divisor_zero_i;
        end
    end

    assign alg_o      = alg_q;
    assign done_o     = done_q;
    assign div_zero_o = dz_q;

endmodule

// File: rtl/seqdiv_dpath.sv
// Module: seqdiv_dpath
// Shared datapath for both schemes: partial remainder acc (W+1 bits, top
// bit is the sign), quotient shift register quo (starts with the dividend)
// and divisor register dvs. One adder/subtractor serves all steps.
// Assumes: at most one of load_i, zload_i, step_i, fix_i is high per cycle.
module seqdiv_dpath
    import seqdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         zload_i,
    input  logic         step_i,
    input  logic         fix_i,
    input  seqdiv_alg_e  alg_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         divisor_zero_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o
);

    localparam int AW = W + 1;

    logic [AW-1:0] acc_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;

    logic [AW-1:0] shifted;
    logic [AW-1:0] lhs;
    logic [AW-1:0] rhs;
    logic          do_sub;
    logic [AW-1:0] sum;
    logic [AW-1:0] acc_next;
    logic          qbit;

    // Flag a zero divisor on the operand inputs
    assign divisor_zero_o = (divisor_i == '0);

    // Form the adder operands: shifted remainder during steps, plain acc in fix
    always_comb begin
        shifted = {acc_q[W-1:0], quo_q[W-1]};
        lhs     = fix_i ? acc_q : shifted;
        rhs     = {1'b0, dvs_q};
        if (fix_i) begin
            do_sub = 1'b0;
        end else if (alg_i == ALG_RESTORE) begin
            do_sub = 1'b1;
        end else begin
            do_sub = !acc_q[W];
        end
    end

    seqdiv_addsub #(
        .WD (AW)
    ) u_addsub (
        .a_i   (lhs),
        .b_i   (rhs),
        .sub_i (do_sub),
        .y_o   (sum)
    );

    // Pick the next remainder and quotient bit for one iteration
    always_comb begin
        if (alg_i == ALG_RESTORE) begin
            acc_next = sum[W] ? shifted : sum;
        end else begin
            acc_next = sum;
        end
        qbit = !sum[W];
    end

    // Remainder, quotient and divisor registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            acc_q <= '0;
            quo_q <= dividend_i;
            dvs_q <= divisor_i;
        end else if (zload_i) begin
            acc_q <= {1'b0, dividend_i};
            quo_q <= '1;
            dvs_q <= '0;
        end else if (step_i) begin
            acc_q <= acc_next;
            quo_q <= {quo_q[W-2:0], qbit};
        end else if (fix_i) begin
            if (acc_q[W]) begin
                acc_q <= sum;
            end
        end
    end

    assign quotient_o  = quo_q;
    assign remainder_o = acc_q[W-1:0];

endmodule

// File: rtl/seqdiv_unit.sv
// Module: seqdiv_unit (top)
// Iterative unsigned divider with per-operation choice of the restoring or
// non-restoring scheme on one shared datapath.
// Assumes: W >= 2; start_i is honoured only while idle.
module seqdiv_unit
    import seqdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         mode_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o,
    output logic         done_o,
    output logic         div_zero_o
);

    logic        load;
    logic        zload;
    logic        step;
    logic        fix;
    logic        busy;
    logic        divisor_zero;
    seqdiv_alg_e alg;

    seqdiv_ctrl #(
        .W (W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .mode_i         (mode_i),
        .divisor_zero_i (divisor_zero),
        .load_o         (load),
        .zload_o        (zload),
        .step_o         (step),
        .fix_o          (fix),
        .alg_o          (alg),
        .busy_o         (busy),
        .done_o         (done_o),
        .div_zero_o     (div_zero_o)
    );

    seqdiv_dpath #(
        .W (W)
    ) u_dpath (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_i         (load),
        .zload_i        (zload),
        .step_i         (step),
        .fix_i          (fix),
        .alg_i          (alg),
        .dividend_i     (dividend_i),
        .divisor_i      (divisor_i),
        .divisor_zero_o (divisor_zero),
        .quotient_o     (quotient_o),
        .remainder_o    (remainder_o)
    );

endmodule

// File: rtl/seqdiv_chk.sv
// Module: seqdiv_chk
// Property checker bound to seqdiv_unit. Records the operands and scheme of
// each accepted operation and checks results, latency and pulse shape.
// Assumes: busy is the top's internal "not idle" signal.
module seqdiv_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         mode_i,
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o,
    input logic         done_o,
    input logic         div_zero_o,
    input logic         busy
);

    localparam int LW = $clog2(W + 3) + 1;
    localparam logic [LW-1:0] LAT_MAX = {LW{1'b1}};

    logic [W-1:0]   cap_dvd;
    logic [W-1:0]   cap_dvs;
    logic           cap_mode;
    logic [LW-1:0]  lat_cnt;
    logic           accept;
    logic [2*W-1:0] recon;

    assign accept = start_i && !busy;
    assign recon  = (2*W)'(quotient_o) * (2*W)'(cap_dvs) + (2*W)'(remainder_o);

    // Record the accepted operation and count cycles since its start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_dvd  <= '0;
            cap_dvs  <= '0;
            cap_mode <= 1'b0;
            lat_cnt  <= '0;
        end else if (accept) begin
            cap_dvd  <= dividend_i;
            cap_dvs  <= divisor_i;
            cap_mode <= mode_i;
            lat_cnt  <= '0;
        end else if (lat_cnt != LAT_MAX) begin
            lat_cnt  <= lat_cnt + 1'b1;
        end
    end

    // R1 R2
    result_math_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o) |-> (recon == (2*W)'(cap_dvd)) && (remainder_o < cap_dvs));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o) |-> (lat_cnt == (cap_mode ? LW'(W + 1) : LW'(W))));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (divisor_i == '0)) |=> (done_o && div_zero_o));

    // R6
    dz_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (divisor_i != '0)) |=> (!div_zero_o && !done_o));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));

endmodule

bind seqdiv_unit seqdiv_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .done_o      (done_o),
    .div_zero_o  (div_zero_o),
    .busy        (busy)
);

// File: tb/seqdiv_unit_bench.sv
// Bench for seqdiv_unit: a vector table walked by one loop, then directed
// tests for reset, divide by zero, ignored starts and held outputs.
module seqdiv_unit_bench;

    localparam int W = 8;
    localparam int NV = 14;
    localparam int LIMIT = 60;

    // Each entry: {mode, dividend, divisor}
    localparam logic [2*W:0] VEC [NV] = '{
        {1'b0, 8'd21,  8'd5},
        {1'b1, 8'd21,  8'd5},
        {1'b0, 8'd255, 8'd1},
        {1'b1, 8'd255, 8'd1},
        {1'b0, 8'd255, 8'd255},
        {1'b1, 8'd254, 8'd255},
        {1'b0, 8'd0,   8'd7},
        {1'b1, 8'd7,   8'd8},
        {1'b0, 8'd200, 8'd3},
        {1'b1, 8'd200, 8'd3},
        {1'b1, 8'd128, 8'd255},
        {1'b0, 8'd254, 8'd127},
        {1'b1, 8'd255, 8'd2},
        {1'b1, 8'd100, 8'd10}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         mode_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic [W-1:0] quotient_o;
    logic [W-1:0] remainder_o;
    logic         done_o;
    logic         div_zero_o;

    int checks = 0;
    int errors = 0;
    int cyc;

    always #4 clk = ~clk;

    seqdiv_unit #(.W(W)) u_seqdiv_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .done_o      (done_o),
        .div_zero_o  (div_zero_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present an operation for one edge, then wait for done; cyc = edges after accept
    task automatic run_op(input logic m, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        mode_i = m; dividend_i = a; divisor_i = b; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < LIMIT) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [W-1:0] hq, hr;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 done at reset", done_o, 0);
        check("R9 dz at reset", div_zero_o, 0);
        check("R9 quotient at reset", quotient_o, 0);
        check("R9 remainder at reset", remainder_o, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: vector table
        for (int i = 0; i < NV; i++) begin
            logic         m;
            logic [W-1:0] a, b;
            {m, a, b} = VEC[i];
            run_op(m, a, b);
            check(m ? "R2 quotient" : "R1 quotient", quotient_o, a / b);
            check(m ? "R2 remainder" : "R1 remainder", remainder_o, a % b);
            check("R3 latency", cyc, m ? W + 1 : W);
            check("R6 no dz flag", div_zero_o, 0);
            @(negedge clk);
            check("R4 pulse width", done_o, 0);
        end

        // R5: divide by zero
        run_op(1'b0, 8'd77, 8'd0);
        check("R5 latency", cyc, 0);
        check("R5 flag", div_zero_o, 1);
        check("R5 quotient", quotient_o, 8'hFF);
        check("R5 remainder", remainder_o, 77);
        @(negedge clk);
        check("R4 zero pulse width", done_o, 0);

        // R6: flag cleared by the next normal operation
        run_op(1'b1, 8'd9, 8'd4);
        check("R6 flag cleared", div_zero_o, 0);
        check("R2 after dz", quotient_o, 2);

        // R7: start and operands ignored while running
        @(negedge clk);
        mode_i = 1'b0; dividend_i = 8'd200; divisor_i = 8'd7; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mode_i = 1'b1; dividend_i = 8'd5; divisor_i = 8'd0;
        cyc = 0;
        while (!done_o && cyc < LIMIT) begin
            if (cyc == W - 3) start_i = 1'b0;
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        check("R7 quotient", quotient_o, 28);
        check("R7 remainder", remainder_o, 4);
        check("R7 latency", cyc, W);
        check("R7 no dz", div_zero_o, 0);

        // R8: outputs held while idle with changing operands
        hq = quotient_o; hr = remainder_o;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            dividend_i = 8'(k * 37); divisor_i = 8'(k); mode_i = k[0];
        end
        check("R8 quotient held", quotient_o, hq);
        check("R8 remainder held", remainder_o, hr);
        check("R8 dz held", div_zero_o, 0);

        // R9: reset in mid-operation suppresses completion
        @(negedge clk);
        mode_i = 1'b1; dividend_i = 8'd99; divisor_i = 8'd4; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        for (int k = 0; k < W + 4; k++) begin
            @(negedge clk);
            if (done_o) cyc++;
        end
        check("R9 no done after reset", cyc, 0);
        check("R9 quotient cleared", quotient_o, 0);
        check("R9 remainder cleared", remainder_o, 0);

        // R1 R2: the block still works after a mid-run reset
        run_op(1'b0, 8'd21, 8'd5);
        check("R1 after reset", {quotient_o, remainder_o}, {8'd4, 8'd1});
        run_op(1'b1, 8'd21, 8'd5);
        check("R2 after reset", {quotient_o, remainder_o}, {8'd4, 8'd1});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule